// File: doc/BRIEF.md
# Handshake Stage Bottleneck Locator

The block watches a chain of `NUM_LINKS` valid/ready links in a streaming path without touching any of them. For each link it also reads the fill level of the buffer that feeds that link. Measurement runs in back-to-back windows of programmable length. In each window the block counts, per link, the cycles with valid high, the cycles with ready high, the completed beats, and the stalled cycles. Stalled cycles are split by which side held the beat back. The block also counts the cycles in which each buffer sat full and the cycles in which it sat empty.

When a window closes, every count is frozen into result registers and a single-cycle `done` pulse is raised. The live counters restart on the very next cycle, so no cycle goes uncounted. The block then works out the sustained rate of the path against the peak of one beat per cycle. If the path runs below 90 % of peak, it names the limiting link and says whether that link is starved from upstream or blocked from downstream. It also marks which buffers stayed full or empty for more than a programmable share of the window.

The block has no valid/ready interface of its own and creates no back-pressure: every input is a probe. The flags and counts it reports give a designer a number to act on, and the next window shows whether the bottleneck has moved.

Top module: `hs_bottleneck_mon`

## Requirements
- R1: For each link, `res_valid_cyc` holds the number of window cycles with valid high, and `res_ready_cyc` holds the number with ready high.
- R2: For each link, `res_xfers` holds the number of window cycles with valid and ready both high.
- R3: A window lasts `win_len` cycles; values 0 and 1 count as 2. The window ends on the first cycle in which the cycles counted so far reach the current `win_len`. `res_window` reports the actual length, and the next window starts on the following cycle with no gap.
- R4: `done` is high for exactly one cycle, two cycles after the last cycle of a window. All results change only together with `done` and hold until the next `done`.
- R5: When a bottleneck is reported, `res_link` is the link with the smallest min(valid cycles, ready cycles). On a tie the lowest-numbered link wins.
- R6: `res_downstream` is 1 when the named link had more consumer-limited stall cycles than producer-limited ones, and 0 otherwise.
- R7: `res_sustained` is the smallest transfer count over all links. When 10·`res_sustained` ≥ 9·`res_window` (90 % or more of peak), `res_found`, `res_link` and `res_downstream` are all 0.
- R8: `res_cons_stall` counts cycles with valid high and ready low; `res_prod_stall` counts cycles with valid low and ready high.
- R9: A link's buffer counts as full when its fill level equals `FIFO_DEPTH`, and as empty when the level is 0. `res_fifo_full[i]` or `res_fifo_empty[i]` is set when 16·(count) ≥ `fifo_thresh`·`res_window`. A `fifo_thresh` of 0 clears both flags. `fifo_thresh` is read one cycle after the window ends.
- R10: Every per-link count stops at 2^`CNT_W`−1 and does not wrap.
- R11: While reset is asserted, `done` and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_len | input | WIN_W | Window length in cycles |
| fifo_thresh | input | 4 | Full/empty share threshold in sixteenths |
| link_valid | input | NUM_LINKS | Observed valid of each link |
| link_ready | input | NUM_LINKS | Observed ready of each link |
| link_fill | input | NUM_LINKS*FILL_W | Fill level of the buffer feeding each link |
| done | output | 1 | One-cycle pulse: new results |
| res_window | output | WIN_W | Length of the reported window |
| res_valid_cyc | output | NUM_LINKS*CNT_W | Valid-high cycles per link |
| res_ready_cyc | output | NUM_LINKS*CNT_W | Ready-high cycles per link |
| res_xfers | output | NUM_LINKS*CNT_W | Completed beats per link |
| res_cons_stall | output | NUM_LINKS*CNT_W | Valid-high, ready-low cycles per link |
| res_prod_stall | output | NUM_LINKS*CNT_W | Valid-low, ready-high cycles per link |
| res_sustained | output | CNT_W | Smallest transfer count over links |
| res_found | output | 1 | A limiting link is named |
| res_link | output | IDX_W | Index of the limiting link |
| res_downstream | output | 1 | 1: blocked by consumer, 0: starved by producer |
| res_fifo_full | output | NUM_LINKS | Buffer sat full above the threshold |
| res_fifo_empty | output | NUM_LINKS | Buffer sat empty above the threshold |

## Verification
On every reported window the assertions check how the outputs relate to each other. A count never exceeds the window length, and beats never exceed valid or ready cycles. Unsaturated valid and ready counts split exactly into beats plus the matching stall class. A named link has the smallest bound and is the first link to reach it, and naming one implies efficiency below 90 %. The bench's scenarios are needed to show the rest: that the counts match the actual stimulus, that window edges lose no cycle even when `win_len` shrinks mid-window, the timing of `done`, saturation, the direction of a stall, and the buffer thresholds.

// File: rtl/hbm_pkg.sv
package hbm_pkg;
  // Index of each per-link event counter inside a link counter bank.
  localparam int NUM_CTR = 7;
  localparam int CTR_V   = 0;  // valid high
  localparam int CTR_R   = 1;  // ready high
  localparam int CTR_X   = 2;  // beat completed
  localparam int CTR_CS  = 3;  // consumer-limited stall
  localparam int CTR_PS  = 4;  // producer-limited stall
  localparam int CTR_FF  = 5;  // buffer full
  localparam int CTR_FE  = 6;  // buffer empty

  typedef enum logic {
    STALL_UP   = 1'b0,
    STALL_DOWN = 1'b1
  } stall_dir_e;
endpackage

// File: rtl/hbm_window_timer.sv
module hbm_window_timer #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end,
  output logic             snap_vld,
  output logic [WIN_W-1:0] snap_len
);
  logic [WIN_W-1:0] cyc;
  logic [WIN_W-1:0] len_eff;
  logic [WIN_W:0]   cyc_p1;

  assign len_eff = (win_len < WIN_W'(2)) ? WIN_W'(2) : win_len;
  assign cyc_p1  = {1'b0, cyc} + 1'b1;
  assign win_end = (cyc_p1 >= {1'b0, len_eff});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc      <= '0;
      snap_len <= '0;
      snap_vld <= 1'b0;
    end else begin
      snap_vld <= win_end;
      if (win_end) begin
        cyc      <= '0;
        snap_len <= cyc_p1[WIN_W-1:0];
      end else begin
        cyc <= cyc_p1[WIN_W-1:0];
      end
    end
  end
endmodule

// File: rtl/hbm_link_counter.sv
module hbm_link_counter
  import hbm_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int FILL_W     = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       valid,
  input  logic                       ready,
  input  logic [FILL_W-1:0]          fill,
  input  logic                       win_end,
  output logic [NUM_CTR*CNT_W-1:0]   snap
);
  logic [NUM_CTR-1:0] evt;

  always_comb begin
    evt         = '0;
    evt[CTR_V]  = valid;
    evt[CTR_R]  = ready;
    evt[CTR_X]  = valid & ready;
    evt[CTR_CS] = valid & ~ready;
    evt[CTR_PS] = ~valid & ready;
    evt[CTR_FF] = (fill == FILL_W'(FIFO_DEPTH));
    evt[CTR_FE] = (fill == '0);
  end

  // One saturating counter per event class; the last window cycle is folded
  // into the snapshot while the live value restarts from zero.
  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    logic [CNT_W-1:0] live;
    logic [CNT_W-1:0] nxt;

    assign nxt = (evt[k] && (live != {CNT_W{1'b1}})) ? live + 1'b1 : live;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        live                  <= '0;
        snap[k*CNT_W +: CNT_W] <= '0;
      end else if (win_end) begin
        live                  <= '0;
        snap[k*CNT_W +: CNT_W] <= nxt;
      end else begin
        live <= nxt;
      end
    end
  end
endmodule

// File: rtl/hbm_analyzer.sv
module hbm_analyzer
  import hbm_pkg::*;
#(
  parameter int NUM_LINKS = 3,
  parameter int CNT_W     = 16,
  parameter int WIN_W     = 16,
  parameter int IDX_W     = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       snap_vld,
  input  logic [3:0]                 thresh,
  input  logic [WIN_W-1:0]           snap_len,
  input  logic [NUM_LINKS*CNT_W-1:0] s_v,
  input  logic [NUM_LINKS*CNT_W-1:0] s_r,
  input  logic [NUM_LINKS*CNT_W-1:0] s_x,
  input  logic [NUM_LINKS*CNT_W-1:0] s_cs,
  input  logic [NUM_LINKS*CNT_W-1:0] s_ps,
  input  logic [NUM_LINKS*CNT_W-1:0] s_ff,
  input  logic [NUM_LINKS*CNT_W-1:0] s_fe,
  output logic                       done,
  output logic [WIN_W-1:0]           res_window,
  output logic [NUM_LINKS*CNT_W-1:0] res_v,
  output logic [NUM_LINKS*CNT_W-1:0] res_r,
  output logic [NUM_LINKS*CNT_W-1:0] res_x,
  output logic [NUM_LINKS*CNT_W-1:0] res_cs,
  output logic [NUM_LINKS*CNT_W-1:0] res_ps,
  output logic [CNT_W-1:0]           res_sust,
  output logic                       res_found,
  output logic [IDX_W-1:0]           res_link,
  output logic                       res_down,
  output logic [NUM_LINKS-1:0]       res_full,
  output logic [NUM_LINKS-1:0]       res_empty
);
  localparam int EW = ((CNT_W > WIN_W) ? CNT_W : WIN_W) + 5;

  logic [CNT_W-1:0]     bnd [NUM_LINKS];
  logic [NUM_LINKS-1:0] full_c, empty_c;
  logic [EW-1:0]        share_lim;

  assign share_lim = EW'(thresh) * EW'(snap_len);

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_link
    logic [CNT_W-1:0] v, r;
    assign v      = s_v[i*CNT_W +: CNT_W];
    assign r      = s_r[i*CNT_W +: CNT_W];
    assign bnd[i] = (v < r) ? v : r;
    assign full_c[i]  = (thresh != 4'd0) &&
                        (EW'({s_ff[i*CNT_W +: CNT_W], 4'b0000}) >= share_lim);
    assign empty_c[i] = (thresh != 4'd0) &&
                        (EW'({s_fe[i*CNT_W +: CNT_W], 4'b0000}) >= share_lim);
  end

  logic [IDX_W-1:0] best_i;
  logic [CNT_W-1:0] best_b;
  logic [CNT_W-1:0] sust;
  logic [CNT_W-1:0] cs_sel, ps_sel;
  logic             eff_ok;
  stall_dir_e       dir;

  always_comb begin
    best_i = '0;
    best_b = bnd[0];
    sust   = s_x[0 +: CNT_W];
    for (int i = 1; i < NUM_LINKS; i++) begin
      if (bnd[i] < best_b) begin
        best_b = bnd[i];
        best_i = IDX_W'(i);
      end
      if (s_x[i*CNT_W +: CNT_W] < sust) sust = s_x[i*CNT_W +: CNT_W];
    end
  end

  assign cs_sel = s_cs[best_i*CNT_W +: CNT_W];
  assign ps_sel = s_ps[best_i*CNT_W +: CNT_W];
  assign dir    = (cs_sel > ps_sel) ? STALL_DOWN : STALL_UP;
  assign eff_ok = (EW'(sust) * EW'(10)) >= (EW'(snap_len) * EW'(9));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done       <= 1'b0;
      res_window <= '0;
      res_v      <= '0;
      res_r      <= '0;
      res_x      <= '0;
      res_cs     <= '0;
      res_ps     <= '0;
      res_sust   <= '0;
      res_found  <= 1'b0;
      res_link   <= '0;
      res_down   <= 1'b0;
      res_full   <= '0;
      res_empty  <= '0;
    end else begin
      done <= snap_vld;
      if (snap_vld) begin
        res_window <= snap_len;
        res_v      <= s_v;
        res_r      <= s_r;
        res_x      <= s_x;
        res_cs     <= s_cs;
        res_ps     <= s_ps;
        res_sust   <= sust;
        res_found  <= ~eff_ok;
        res_link   <= eff_ok ? '0 : best_i;
        res_down   <= eff_ok ? 1'b0 : (dir == STALL_DOWN);
        res_full   <= full_c;
        res_empty  <= empty_c;
      end
    end
  end
endmodule

// File: rtl/hs_bottleneck_mon.sv
module hs_bottleneck_mon
  import hbm_pkg::*;
#(
  parameter int NUM_LINKS  = 3,
  parameter int CNT_W      = 16,
  parameter int WIN_W      = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int FILL_W     = $clog2(FIFO_DEPTH + 1),
  parameter int IDX_W      = (NUM_LINKS > 1) ? $clog2(NUM_LINKS) : 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [WIN_W-1:0]               win_len,
  input  logic [3:0]                     fifo_thresh,
  input  logic [NUM_LINKS-1:0]           link_valid,
  input  logic [NUM_LINKS-1:0]           link_ready,
  input  logic [NUM_LINKS*FILL_W-1:0]    link_fill,
  output logic                           done,
  output logic [WIN_W-1:0]               res_window,
  output logic [NUM_LINKS*CNT_W-1:0]     res_valid_cyc,
  output logic [NUM_LINKS*CNT_W-1:0]     res_ready_cyc,
  output logic [NUM_LINKS*CNT_W-1:0]     res_xfers,
  output logic [NUM_LINKS*CNT_W-1:0]     res_cons_stall,
  output logic [NUM_LINKS*CNT_W-1:0]     res_prod_stall,
  output logic [CNT_W-1:0]               res_sustained,
  output logic                           res_found,
  output logic [IDX_W-1:0]               res_link,
  output logic                           res_downstream,
  output logic [NUM_LINKS-1:0]           res_fifo_full,
  output logic [NUM_LINKS-1:0]           res_fifo_empty
);
  logic             win_end, snap_vld;
  logic [WIN_W-1:0] snap_len;

  logic [NUM_LINKS*CNT_W-1:0] s_v, s_r, s_x, s_cs, s_ps, s_ff, s_fe;

  hbm_window_timer #(.WIN_W(WIN_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .win_len  (win_len),
    .win_end  (win_end),
    .snap_vld (snap_vld),
    .snap_len (snap_len)
  );

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_bank
    logic [NUM_CTR*CNT_W-1:0] snap;

    hbm_link_counter #(
      .CNT_W      (CNT_W),
      .FIFO_DEPTH (FIFO_DEPTH),
      .FILL_W     (FILL_W)
    ) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .valid   (link_valid[i]),
      .ready   (link_ready[i]),
      .fill    (link_fill[i*FILL_W +: FILL_W]),
      .win_end (win_end),
      .snap    (snap)
    );

    assign s_v [i*CNT_W +: CNT_W] = snap[CTR_V *CNT_W +: CNT_W];
    assign s_r [i*CNT_W +: CNT_W] = snap[CTR_R *CNT_W +: CNT_W];
    assign s_x [i*CNT_W +: CNT_W] = snap[CTR_X *CNT_W +: CNT_W];
    assign s_cs[i*CNT_W +: CNT_W] = snap[CTR_CS*CNT_W +: CNT_W];
    assign s_ps[i*CNT_W +: CNT_W] = snap[CTR_PS*CNT_W +: CNT_W];
    assign s_ff[i*CNT_W +: CNT_W] = snap[CTR_FF*CNT_W +: CNT_W];
    assign s_fe[i*CNT_W +: CNT_W] = snap[CTR_FE*CNT_W +: CNT_W];
  end

  hbm_analyzer #(
    .NUM_LINKS (NUM_LINKS),
    .CNT_W     (CNT_W),
    .WIN_W     (WIN_W),
    .IDX_W     (IDX_W)
  ) u_ana (
    .clk        (clk),
    .rst_n      (rst_n),
    .snap_vld   (snap_vld),
    .thresh     (fifo_thresh),
    .snap_len   (snap_len),
    .s_v        (s_v),
    .s_r        (s_r),
    .s_x        (s_x),
    .s_cs       (s_cs),
    .s_ps       (s_ps),
    .s_ff       (s_ff),
    .s_fe       (s_fe),
    .done       (done),
    .res_window (res_window),
    .res_v      (res_valid_cyc),
    .res_r      (res_ready_cyc),
    .res_x      (res_xfers),
    .res_cs     (res_cons_stall),
    .res_ps     (res_prod_stall),
    .res_sust   (res_sustained),
    .res_found  (res_found),
    .res_link   (res_link),
    .res_down   (res_downstream),
    .res_full   (res_fifo_full),
    .res_empty  (res_fifo_empty)
  );
endmodule

// File: rtl/hs_bottleneck_mon_chk.sv
module hs_bottleneck_mon_chk #(
  parameter int NUM_LINKS = 3,
  parameter int CNT_W     = 16,
  parameter int WIN_W     = 16,
  parameter int IDX_W     = 2
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       done,
  input logic [WIN_W-1:0]           res_window,
  input logic [NUM_LINKS*CNT_W-1:0] res_valid_cyc,
  input logic [NUM_LINKS*CNT_W-1:0] res_ready_cyc,
  input logic [NUM_LINKS*CNT_W-1:0] res_xfers,
  input logic [NUM_LINKS*CNT_W-1:0] res_cons_stall,
  input logic [NUM_LINKS*CNT_W-1:0] res_prod_stall,
  input logic [CNT_W-1:0]           res_sustained,
  input logic                       res_found,
  input logic [IDX_W-1:0]           res_link
);
  logic [CNT_W-1:0] bnd [NUM_LINKS];
  logic [CNT_W-1:0] bnd_sel;

  always_comb begin
    for (int i = 0; i < NUM_LINKS; i++) begin
      bnd[i] = (res_valid_cyc[i*CNT_W +: CNT_W] < res_ready_cyc[i*CNT_W +: CNT_W]) ?
               res_valid_cyc[i*CNT_W +: CNT_W] : res_ready_cyc[i*CNT_W +: CNT_W];
    end
    bnd_sel = '0;
    for (int i = 0; i < NUM_LINKS; i++) begin
      if (res_link == IDX_W'(i)) bnd_sel = bnd[i];
    end
  end

  for (genvar i = 0; i < NUM_LINKS; i++) begin : g_chk
    logic [CNT_W-1:0] v, r, x, cs, ps;
    assign v  = res_valid_cyc [i*CNT_W +: CNT_W];
    assign r  = res_ready_cyc [i*CNT_W +: CNT_W];
    assign x  = res_xfers     [i*CNT_W +: CNT_W];
    assign cs = res_cons_stall[i*CNT_W +: CNT_W];
    assign ps = res_prod_stall[i*CNT_W +: CNT_W];

    // R1
    valid_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (32'(v) <= 32'(res_window)) && (32'(r) <= 32'(res_window)));

    // R2
    beats_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (x <= v) && (x <= r));

    // R8
    valid_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (v != {CNT_W{1'b1}})) |-> (({1'b0, x} + {1'b0, cs}) == {1'b0, v}));

    // R8
    ready_split_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (r != {CNT_W{1'b1}})) |-> (({1'b0, x} + {1'b0, ps}) == {1'b0, r}));

    // R5
    named_is_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_found) |-> (bnd_sel <= bnd[i]));

    // R5
    tie_low_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && res_found && (IDX_W'(i) < res_link)) |-> (bnd[i] > bnd_sel));
  end

  // R7
  found_means_slow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && res_found) |-> ((40'(res_sustained) * 40'd10) < (40'(res_window) * 40'd9)));

  // R4
  results_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> (done || ($stable(res_window) && $stable(res_found) && $stable(res_sustained))));
endmodule

bind hs_bottleneck_mon hs_bottleneck_mon_chk #(
  .NUM_LINKS (NUM_LINKS),
  .CNT_W     (CNT_W),
  .WIN_W     (WIN_W),
  .IDX_W     (IDX_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .done           (done),
  .res_window     (res_window),
  .res_valid_cyc  (res_valid_cyc),
  .res_ready_cyc  (res_ready_cyc),
  .res_xfers      (res_xfers),
  .res_cons_stall (res_cons_stall),
  .res_prod_stall (res_prod_stall),
  .res_sustained  (res_sustained),
  .res_found      (res_found),
  .res_link       (res_link)
);

// File: tb/hs_bottleneck_mon_bench.sv
module hs_bottleneck_mon_bench;
  localparam int N          = 3;
  localparam int CNT_W      = 8;
  localparam int WIN_W      = 12;
  localparam int DEPTH      = 8;
  localparam int FILL_W     = 4;
  localparam int IDX_W      = 2;
  localparam int CMAX       = (1 << CNT_W) - 1;
  localparam int CLK_PERIOD = 10;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [WIN_W-1:0]       win_len = '0;
  logic [3:0]             fifo_thresh = '0;
  logic [N-1:0]           link_valid = '0;
  logic [N-1:0]           link_ready = '0;
  logic [N*FILL_W-1:0]    link_fill = '0;
  logic                   done;
  logic [WIN_W-1:0]       res_window;
  logic [N*CNT_W-1:0]     res_valid_cyc, res_ready_cyc, res_xfers;
  logic [N*CNT_W-1:0]     res_cons_stall, res_prod_stall;
  logic [CNT_W-1:0]       res_sustained;
  logic                   res_found;
  logic [IDX_W-1:0]       res_link;
  logic                   res_downstream;
  logic [N-1:0]           res_fifo_full, res_fifo_empty;

  always #(CLK_PERIOD/2) clk = ~clk;

  hs_bottleneck_mon #(
    .NUM_LINKS (N), .CNT_W (CNT_W), .WIN_W (WIN_W), .FIFO_DEPTH (DEPTH)
  ) u_hs_bottleneck_mon (
    .clk (clk), .rst_n (rst_n), .win_len (win_len), .fifo_thresh (fifo_thresh),
    .link_valid (link_valid), .link_ready (link_ready), .link_fill (link_fill),
    .done (done), .res_window (res_window), .res_valid_cyc (res_valid_cyc),
    .res_ready_cyc (res_ready_cyc), .res_xfers (res_xfers),
    .res_cons_stall (res_cons_stall), .res_prod_stall (res_prod_stall),
    .res_sustained (res_sustained), .res_found (res_found), .res_link (res_link),
    .res_downstream (res_downstream), .res_fifo_full (res_fifo_full),
    .res_fifo_empty (res_fifo_empty)
  );

  // Scenario knobs (percent chances per link)
  int pv[N], pr[N], pf[N], pe[N];
  bit shared;
  int cur_len, cur_thr;

  // Live model counts
  int m_v[N], m_r[N], m_x[N], m_cs[N], m_ps[N], m_ff[N], m_fe[N];
  int m_cnt;

  // Expected results of the last closed window
  int e_v[N], e_r[N], e_x[N], e_cs[N], e_ps[N], e_ff[N], e_fe[N];
  int e_win, e_sust, e_found, e_link, e_down, e_thr;
  bit pend;
  int cd;
  bit have;
  int h_win, h_found;

  int checks = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit chance(int p);
    return ($urandom_range(99) < p);
  endfunction

  function automatic int sat(int c, bit inc);
    return (inc && c < CMAX) ? c + 1 : c;
  endfunction

  task automatic close_window();
    int bmin, bi, sm;
    e_win = m_cnt;
    for (int i = 0; i < N; i++) begin
      e_v[i] = m_v[i]; e_r[i] = m_r[i]; e_x[i] = m_x[i];
      e_cs[i] = m_cs[i]; e_ps[i] = m_ps[i]; e_ff[i] = m_ff[i]; e_fe[i] = m_fe[i];
    end
    bmin = -1; bi = 0; sm = -1;
    for (int i = 0; i < N; i++) begin
      int b;
      b = (e_v[i] < e_r[i]) ? e_v[i] : e_r[i];
      if (bmin < 0 || b < bmin) begin bmin = b; bi = i; end
      if (sm < 0 || e_x[i] < sm) sm = e_x[i];
    end
    e_sust = sm;
    if (sm * 10 >= e_win * 9) begin
      e_found = 0; e_link = 0; e_down = 0;
    end else begin
      e_found = 1; e_link = bi; e_down = (e_cs[bi] > e_ps[bi]) ? 1 : 0;
    end
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_r[i] = 0; m_x[i] = 0; m_cs[i] = 0;
      m_ps[i] = 0; m_ff[i] = 0; m_fe[i] = 0;
    end
    m_cnt = 0;
    pend = 1; cd = 2;
  endtask

  task automatic drive_and_model();
    bit v0, r0;
    int le;
    win_len     = WIN_W'(cur_len);
    fifo_thresh = 4'(cur_thr);
    for (int i = 0; i < N; i++) begin
      bit v, r;
      int f;
      v = chance(pv[i]); r = chance(pr[i]);
      if (i == 0) begin v0 = v; r0 = r; end
      if (shared) begin v = v0; r = r0; end
      if (chance(pf[i])) f = DEPTH;
      else if (chance(pe[i])) f = 0;
      else f = $urandom_range(DEPTH-1, 1);
      link_valid[i] = v;
      link_ready[i] = r;
      link_fill[i*FILL_W +: FILL_W] = FILL_W'(f);
      m_v[i]  = sat(m_v[i], v);
      m_r[i]  = sat(m_r[i], r);
      m_x[i]  = sat(m_x[i], v & r);
      m_cs[i] = sat(m_cs[i], v & ~r);
      m_ps[i] = sat(m_ps[i], ~v & r);
      m_ff[i] = sat(m_ff[i], f == DEPTH);
      m_fe[i] = sat(m_fe[i], f == 0);
    end
    m_cnt++;
    le = (cur_len < 2) ? 2 : cur_len;
    if (m_cnt >= le) close_window();
  endtask

  task automatic compare();
    bit due;
    due = 0;
    if (pend) begin
      cd--;
      if (cd == 1) e_thr = cur_thr;   // threshold seen at the analysis edge
      if (cd == 0) due = 1;
    end
    chk("R4", "done pulse", done, due);
    if (due) begin
      pend = 0;
      chk("R3", "window length", res_window, e_win);
      for (int i = 0; i < N; i++) begin
        bit ef, ee;
        chk((e_v[i] == CMAX) ? "R10" : "R1", $sformatf("valid cycles link%0d", i),
            res_valid_cyc[i*CNT_W +: CNT_W], e_v[i]);
        chk((e_r[i] == CMAX) ? "R10" : "R1", $sformatf("ready cycles link%0d", i),
            res_ready_cyc[i*CNT_W +: CNT_W], e_r[i]);
        chk((e_x[i] == CMAX) ? "R10" : "R2", $sformatf("beats link%0d", i),
            res_xfers[i*CNT_W +: CNT_W], e_x[i]);
        chk("R8", $sformatf("consumer stalls link%0d", i),
            res_cons_stall[i*CNT_W +: CNT_W], e_cs[i]);
        chk("R8", $sformatf("producer stalls link%0d", i),
            res_prod_stall[i*CNT_W +: CNT_W], e_ps[i]);
        ef = (e_thr != 0) && (e_ff[i] * 16 >= e_thr * e_win);
        ee = (e_thr != 0) && (e_fe[i] * 16 >= e_thr * e_win);
        chk("R9", $sformatf("full flag link%0d", i), res_fifo_full[i], ef);
        chk("R9", $sformatf("empty flag link%0d", i), res_fifo_empty[i], ee);
      end
      chk("R7", "sustained", res_sustained, e_sust);
      chk("R7", "found", res_found, e_found);
      chk("R5", "limiting link", res_link, e_link);
      chk("R6", "direction", res_downstream, e_down);
      h_win = e_win; h_found = e_found; have = 1;
    end else if (have) begin
      chk("R4", "held window", res_window, h_win);
      chk("R4", "held found", res_found, h_found);
    end
  endtask

  task automatic step(int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      compare();
      drive_and_model();
    end
  endtask

  task automatic setup(int len, int thr, bit sh);
    cur_len = len; cur_thr = thr; shared = sh;
  endtask

  task automatic summary();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL R4 watchdog: actual 0 expected 1 (run did not end)");
      summary();
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      pv[i] = 100; pr[i] = 100; pf[i] = 0; pe[i] = 0;
      m_v[i] = 0; m_r[i] = 0; m_x[i] = 0; m_cs[i] = 0;
      m_ps[i] = 0; m_ff[i] = 0; m_fe[i] = 0;
    end
    m_cnt = 0; pend = 0; cd = 0; have = 0; e_thr = 0;
    setup(20, 12, 0);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "done in reset", done, 0);
    chk("R11", "found in reset", res_found, 0);
    chk("R11", "window in reset", res_window, 0);
    chk("R11", "valid count in reset", res_valid_cyc, 0);
    chk("R11", "fifo flags in reset", {res_fifo_full, res_fifo_empty}, 0);
    rst_n = 1'b1;
    drive_and_model();

    // Consumer side of link 1 throttled; buffer 0 mostly full, buffer 2 empty.
    pv = '{90, 90, 90}; pr = '{95, 30, 95};
    pf = '{90, 10, 0};  pe = '{0, 10, 90};
    step(300);

    // Full rate everywhere: no bottleneck, empty buffers.
    pv = '{100, 100, 100}; pr = '{100, 100, 100};
    pf = '{0, 0, 0}; pe = '{100, 100, 100};
    setup(16, 8, 0);
    step(200);

    // Producer side of link 2 throttled.
    pv = '{95, 95, 20}; pr = '{95, 95, 100};
    pf = '{20, 20, 20}; pe = '{20, 20, 20};
    setup(25, 4, 0);
    step(200);

    // Identical traffic on every link: tie goes to link 0.
    pv = '{60, 60, 60}; pr = '{50, 50, 50};
    setup(18, 15, 1);
    step(200);

    // Minimum window lengths.
    setup(0, 1, 0);
    step(20);
    setup(1, 16 - 1, 0);
    step(20);

    // Window shortened while one is open.
    setup(30, 6, 0);
    step(10);
    setup(5, 6, 0);
    step(60);

    // Long window at full rate: counters saturate; threshold 0.
    pv = '{100, 100, 100}; pr = '{100, 100, 100};
    pf = '{100, 0, 0}; pe = '{0, 100, 0};
    setup(300, 0, 0);
    step(700);

    step(4);
    summary();
  end
endmodule